// File: doc/BRIEF.md
# UART Modem Status Register

This block holds the modem-status byte of one 16550-style serial channel. Four active-low handshake lines enter it: carrier detect, ring indicator, data-set-ready and clear-to-send. Each line is brought into the clock domain by a chain of flip-flops. The upper nibble of the byte reports the active-high level of each line. The lower nibble holds a sticky flag per line that records a qualifying change since the host last read the byte. A read strobe clears the flags. Any flag that is set drives a level-sensitive interrupt request.

In loopback mode the four levels come from modem-control outputs of the same channel instead of the pins. Changes caused by loopback are flagged exactly like pin changes.

A two-state machine guards start-up. After reset it sits in `ST_FILL` while the synchronizer chain settles. During this time the stored previous levels track the live levels and no flag can set. It moves to `ST_ARMED` on the transition `FILL_DONE`, which happens once the fill counter has reached `SYNC_STAGES`. Reset is the only way back to `ST_FILL` (transition `RESET_ENTRY`). Change detection runs only in `ST_ARMED`.

Top module: `uart_modem_status`

## Requirements
- R1: With loopback off, `status_o[7]`, `[6]`, `[5]`, `[4]` are the complements of `cd_n`, `ri_n`, `dsr_n`, `cts_n`. The value is visible two clock edges after a pin changes (`SYNC_STAGES` = 2).
- R2: `status_o[3]`, `[2]`, `[1]`, `[0]` are the change flags for carrier detect, ring, data-set-ready and clear-to-send, in that order.
- R3: The carrier, data-set-ready and clear-to-send flags set on a change of their level in either direction. With loopback off, the flag is set three edges after the pin changes.
- R4: The ring flag sets only when `ri_n` goes from 0 to 1, which means the ring level in `status_o[6]` falls from 1 to 0. A 1-to-0 change on `ri_n` leaves the flag clear.
- R5: A cycle with `rd_strobe` high clears all four flags at that clock edge.
- R6: A qualifying change whose flag would set at the same edge as a read leaves that flag set. Older flags are still cleared.
- R7: `irq_o` is 1 exactly when at least one of `status_o[3:0]` is 1.
- R8: With `loopback_en` = 1, the levels come from `mcr_bits`: carrier = `mcr_bits[3]`, ring = `mcr_bits[2]`, data-set-ready = `mcr_bits[0]`, clear-to-send = `mcr_bits[1]`. The levels follow `mcr_bits` with no register delay.
- R9: A level change caused by an `mcr_bits` toggle in loopback, or by entering or leaving loopback, sets flags under the rules of R3 and R4 at the next clock edge.
- R10: After reset, `irq_o` and all flags are 0. Pin levels held throughout reset produce no flag once the synchronizers have settled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cd_n | input | 1 | Carrier detect pin, active low, asynchronous |
| ri_n | input | 1 | Ring indicator pin, active low, asynchronous |
| dsr_n | input | 1 | Data-set-ready pin, active low, asynchronous |
| cts_n | input | 1 | Clear-to-send pin, active low, asynchronous |
| loopback_en | input | 1 | Selects modem-control bits in place of the pins |
| mcr_bits | input | 4 | Modem-control outputs used in loopback |
| rd_strobe | input | 1 | One cycle high for each host read of the byte |
| status_o | output | 8 | Levels in [7:4], change flags in [3:0] |
| irq_o | output | 1 | Modem-status interrupt request |

## Verification
A pin change driven on a falling clock edge reaches the level bits two rising edges later and the flags three rising edges later. The bench therefore samples the levels on the second falling edge after the change and the flags on the third. A loopback change passes through no register, so its levels and flags are both sampled on the first falling edge after it is driven. A read strobe is driven for one cycle, and the cleared flags are sampled on the falling edge that follows it. The coincident-read test raises the strobe on the second falling edge after a pin change, so the read and the flag-setting edge are the same clock edge.

// File: rtl/msr_pkg.sv
package msr_pkg;
    localparam int NUM_LINES = 4;
    // Line positions inside a nibble; the byte layout depends on this order.
    localparam int IDX_CD  = 3;
    localparam int IDX_RI  = 2;
    localparam int IDX_DSR = 1;
    localparam int IDX_CTS = 0;

    typedef enum logic {
        ST_FILL  = 1'b0,
        ST_ARMED = 1'b1
    } msr_state_e;
endpackage

// File: rtl/msr_sync.sv
module msr_sync #(
    parameter int                 WIDTH     = 4,
    parameter int                 STAGES    = 2,
    parameter logic [WIDTH-1:0]   RESET_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= RESET_VAL;
                    else        stage_q[s] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= RESET_VAL;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/msr_arm_fsm.sv
module msr_arm_fsm
    import msr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic armed_o
);
    localparam int CNT_W = $clog2(SYNC_STAGES + 1);
    localparam logic [CNT_W-1:0] FILL_LAST = CNT_W'(SYNC_STAGES);

    msr_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // State register (RESET_ENTRY lands in ST_FILL)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FILL;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state and outputs
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        armed_o = 1'b0;
        unique case (state_q)
            ST_FILL: begin
                if (cnt_q == FILL_LAST) state_d = ST_ARMED; // FILL_DONE
                else                    cnt_d   = cnt_q + 1'b1;
            end
            ST_ARMED: begin
                armed_o = 1'b1;
            end
        endcase
    end

    assert_fill_leaves_once_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED) |=> (state_q == ST_ARMED));
endmodule

// File: rtl/msr_change_det.sv
module msr_change_det #(
    parameter int               WIDTH     = 4,
    parameter logic [WIDTH-1:0] FALL_ONLY = 4'b0100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             armed_i,
    input  logic             rd_clr_i,
    input  logic [WIDTH-1:0] lvl_i,
    output logic [WIDTH-1:0] flags_o
);
    logic [WIDTH-1:0] prev_q;
    logic [WIDTH-1:0] flag_q;
    logic [WIDTH-1:0] event_w;

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_line
            if (FALL_ONLY[i]) begin : g_fall
                assign event_w[i] = armed_i & prev_q[i] & ~lvl_i[i];
                assert_ring_trailing_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
                    $rose(flag_q[i]) |-> ($past(prev_q[i]) && !$past(lvl_i[i])));
            end else begin : g_any
                assign event_w[i] = armed_i & (prev_q[i] ^ lvl_i[i]);
                assert_any_edge_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
                    (armed_i && (prev_q[i] != lvl_i[i])) |=> flag_q[i]);
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
            flag_q <= '0;
        end else begin
            prev_q <= lvl_i;
            flag_q <= (flag_q & ~{WIDTH{rd_clr_i}}) | event_w;
        end
    end

    assign flags_o = flag_q;

    assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr_i && (event_w == '0)) |=> (flag_q == '0));
    assert_event_survives_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr_i && (event_w != '0)) |=> ((flag_q & $past(event_w)) == $past(event_w)));
    assert_quiet_while_filling_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !armed_i |-> (flag_q == '0));
endmodule

// File: rtl/uart_modem_status.sv
module uart_modem_status
    import msr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cd_n,
    input  logic       ri_n,
    input  logic       dsr_n,
    input  logic       cts_n,
    input  logic       loopback_en,
    input  logic [3:0] mcr_bits,
    input  logic       rd_strobe,
    output logic [7:0] status_o,
    output logic       irq_o
);
    localparam logic [NUM_LINES-1:0] RING_MASK = NUM_LINES'(1) << IDX_RI;

    logic [NUM_LINES-1:0] pins_n;
    logic [NUM_LINES-1:0] pins_sync_n;
    logic [NUM_LINES-1:0] lb_lvl;
    logic [NUM_LINES-1:0] lvl;
    logic [NUM_LINES-1:0] flags;
    logic                 armed;

    always_comb begin
        pins_n          = '0;
        pins_n[IDX_CD]  = cd_n;
        pins_n[IDX_RI]  = ri_n;
        pins_n[IDX_DSR] = dsr_n;
        pins_n[IDX_CTS] = cts_n;
        lb_lvl          = '0;
        lb_lvl[IDX_CD]  = mcr_bits[3];
        lb_lvl[IDX_RI]  = mcr_bits[2];
        lb_lvl[IDX_DSR] = mcr_bits[0];
        lb_lvl[IDX_CTS] = mcr_bits[1];
    end

    msr_sync #(
        .WIDTH     (NUM_LINES),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL ('1)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pins_n),
        .sync_o  (pins_sync_n)
    );

    assign lvl = loopback_en ? lb_lvl : ~pins_sync_n;

    msr_arm_fsm #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .armed_o (armed)
    );

    msr_change_det #(
        .WIDTH     (NUM_LINES),
        .FALL_ONLY (RING_MASK)
    ) u_det (
        .clk      (clk),
        .rst_n    (rst_n),
        .armed_i  (armed),
        .rd_clr_i (rd_strobe),
        .lvl_i    (lvl),
        .flags_o  (flags)
    );

    assign status_o = {lvl, flags};
    assign irq_o    = |flags;

    assert_irq_drops_after_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && rd_strobe && $stable(lvl) && armed) |=> !irq_o);
endmodule

// File: tb/uart_modem_status_tb.sv
`timescale 1ns/1ps
module uart_modem_status_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] pins;          // {cd_n, ri_n, dsr_n, cts_n}
    logic       loopback_en;
    logic [3:0] mcr_bits;
    logic       rd_strobe;
    logic [7:0] status_o;
    logic       irq_o;

    int checks = 0;
    int errors = 0;
    logic [3:0] model_lvl;

    always #2.5 clk = ~clk;

    uart_modem_status u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cd_n        (pins[3]),
        .ri_n        (pins[2]),
        .dsr_n       (pins[1]),
        .cts_n       (pins[0]),
        .loopback_en (loopback_en),
        .mcr_bits    (mcr_bits),
        .rd_strobe   (rd_strobe),
        .status_o    (status_o),
        .irq_o       (irq_o)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] map_mcr(input logic [3:0] m);
        return {m[3], m[2], m[0], m[1]};
    endfunction

    function automatic logic [3:0] qual(input logic [3:0] o, input logic [3:0] n);
        return ((o ^ n) & 4'b1011) | (o & ~n & 4'b0100);
    endfunction

    task automatic do_read();
        @(negedge clk) rd_strobe = 1'b1;
        @(negedge clk) rd_strobe = 1'b0;
        chk("R5 flags cleared", {4'h0, status_o[3:0]}, 8'h00);
        chk("R5 irq low", {7'h0, irq_o}, 8'h00);
    endtask

    // Loopback step driven with a read in the same cycle: flags equal new events only.
    task automatic lb_step(input logic lb, input logic [3:0] m);
        logic [3:0] nl;
        logic [3:0] ex;
        nl = lb ? map_mcr(m) : ~pins;
        ex = qual(model_lvl, nl);
        @(negedge clk);
        loopback_en = lb; mcr_bits = m; rd_strobe = 1'b1;
        @(negedge clk) rd_strobe = 1'b0;
        chk("R8 loopback levels", {4'h0, status_o[7:4]}, {4'h0, nl});
        chk("R9 R6 loopback flags", {4'h0, status_o[3:0]}, {4'h0, ex});
        chk("R7 irq", {7'h0, irq_o}, {7'h0, (ex != 4'h0)});
        model_lvl = nl;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; pins = 4'b0000; loopback_en = 1'b0; mcr_bits = 4'h0; rd_strobe = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10 irq in reset", {7'h0, irq_o}, 8'h00);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        chk("R10 R1 held pins give levels, no flags", status_o, 8'hF0);
        chk("R10 irq after reset", {7'h0, irq_o}, 8'h00);

        // All pins release: three any-edge flags and ring 0->1 on ri_n.
        pins = 4'b1111;
        repeat (2) @(negedge clk);
        chk("R1 levels after release", {4'h0, status_o[7:4]}, 8'h00);
        @(negedge clk);
        chk("R3 R4 R2 all flags", {4'h0, status_o[3:0]}, 8'h0F);
        chk("R7 irq set", {7'h0, irq_o}, 8'h01);
        do_read();

        // Sweep each pin through both directions.
        for (int b = 0; b < 4; b++) begin
            for (int step = 0; step < 2; step++) begin
                logic [3:0] np;
                logic [3:0] ex;
                np = pins ^ (4'b0001 << b);
                ex = qual(~pins, ~np);
                @(negedge clk) pins = np;
                repeat (2) @(negedge clk);
                chk("R1 pin level", {4'h0, status_o[7:4]}, {4'h0, ~np});
                @(negedge clk);
                chk(b == 2 ? "R4 ring flag" : "R3 change flag", {4'h0, status_o[3:0]}, {4'h0, ex});
                chk("R7 irq follows flags", {7'h0, irq_o}, {7'h0, (ex != 4'h0)});
                do_read();
            end
        end

        // Coincident read: dsr flag is old, cts flag sets at the read edge.
        @(negedge clk) pins = pins ^ 4'b0010;
        repeat (3) @(negedge clk);
        chk("R3 dsr flag", {4'h0, status_o[3:0]}, 8'h02);
        pins = pins ^ 4'b0001;
        repeat (2) @(negedge clk);
        rd_strobe = 1'b1;
        @(negedge clk) rd_strobe = 1'b0;
        chk("R6 event kept at read", {4'h0, status_o[3:0]}, 8'h01);
        do_read();

        // Loopback sweep over all control values, then leave loopback.
        model_lvl = ~pins;
        for (int i = 0; i < 34; i++) begin
            lb_step(1'b1, 4'((i * 7 + 3) & 15));
        end
        lb_step(1'b0, 4'h0);
        lb_step(1'b1, 4'hF);
        lb_step(1'b0, 4'hF);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule